// File: doc/BRIEF.md
# Coprocessor State-Save Format Responder

This block sits on the coprocessor side of a main-processor/coprocessor link. It answers a read of the save register with a 16-bit format word that reflects the unit's current execution phase. When the word announces an idle or busy frame, the main processor then pulls the saved state through a 32-bit operand register, one longword per read. When the last longword has gone out, the unit is idle again.

The phase is driven by a few event inputs from the surrounding unit: instruction start and finish, restore start and end, and suspension and resumption of a save or restore. There is also an abort written to the control register. The arithmetic unit is not part of this block. The frame contents come from a stub register file whose values are computed from the longword index.

Each read is answered one clock later. A save read has priority over an operand read in the same cycle, and an abort has priority over both.

Top module: `cp_save_resp`

## Requirements
- R1: A save read is answered in the following cycle with `fmt_vld_o` high for exactly one cycle. Bits 15:8 of `fmt_o` carry the state or version code and bits 7:0 the frame size in bytes. After reset all outputs are zero.
- R2: After reset, or after a restore that ends with `rstr_null_i` high, a save read returns 0x0000. The phase does not change, so a repeated read returns 0x0000 again.
- R3: In the idle phase a save read returns {VERSION, idle size}. In the busy phase with `freeze_i` low it returns {VERSION, busy size}. The sizes are 0x18 and 0xB4 for VARIANT 0, and 0x38 and 0xD4 for VARIANT 1. VERSION is nonzero.
- R4: In the busy phase with `freeze_i` high, a save read returns 0x0100 and the unit stays busy.
- R5: A save read while a save transfer, a restore or a suspension is under way returns 0x0200. It leaves that activity untouched. The null, come-again and illegal words always carry size 0x00.
- R6: After an idle or busy word, the frame holds size/4 longwords, and each operand read returns the next one. The index counts down from size/4-1 to 0. Each longword is {tag, index[7:0], 16'hC0DE ^ {index[7:0], index[7:0]}}, where the tag is 0x1D for an idle frame and 0xB5 for a busy frame.
- R7: After the last longword has been read, the unit is in the idle phase, so the next save read returns the idle word.
- R8: An operand read that finds no frame longword pending returns `opnd_o` = 0 with `opnd_vld_o` low and `proto_err_o` high for one cycle. This covers a read past the end of the frame or a read with no save active.
- R9: An abort in any phase discards the context and returns the unit to the null phase. After it, a resume has no effect, operand reads raise the protocol error, and save reads return 0x0000.
- R10: A suspend during a save transfer or a restore holds it. Operand reads are then protocol errors. A resume continues the transfer at the next pending longword.
- R11: An instruction start in the null or idle phase enters busy, and an instruction finish in busy enters idle. A restore start in the null or idle phase enters the restore phase. A restore end leaves it for null or idle, selected by `rstr_null_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_rd_i | input | 1 | Read strobe of the save register |
| freeze_i | input | 1 | Unit cannot freeze its state yet (come-again) |
| fmt_o | output | 16 | Format word |
| fmt_vld_o | output | 1 | Format word valid pulse |
| opnd_rd_i | input | 1 | Read strobe of the operand register |
| opnd_o | output | 32 | Frame longword |
| opnd_vld_o | output | 1 | Frame longword valid pulse |
| proto_err_o | output | 1 | Operand read with no longword pending |
| ctrl_abort_i | input | 1 | Abort written to the control register |
| exec_start_i | input | 1 | Instruction execution begins |
| exec_done_i | input | 1 | Instruction execution completes |
| rstr_start_i | input | 1 | State restore begins |
| rstr_end_i | input | 1 | State restore completes |
| rstr_null_i | input | 1 | Completed restore was a null frame |
| suspend_i | input | 1 | Save or restore suspended |
| resume_i | input | 1 | Suspended save or restore resumes |

## Verification
The assertions check these rules on every cycle:
- each read is answered one cycle later;
- format words take only the legal codes;
- a null, come-again or illegal word carries size zero;
- a protocol error never comes with data;
- an abort cycle yields no frame data.

Only the bench scenarios can show the phase-dependent parts: which word each phase returns, the descending order and contents of a streamed frame, the return to idle after the last longword, and holding across a suspension. The same goes for the loss of context after an abort. A bench-side phase model checks these under directed sequences and random event mixes.

// File: rtl/cp_save_pkg.sv
package cp_save_pkg;

  typedef enum logic [2:0] {
    PH_NULL, PH_IDLE, PH_BUSY, PH_XFER, PH_RSTR, PH_SUSP
  } phase_e;

  typedef enum logic [2:0] {
    W_NULL, W_CAGAIN, W_ILLEGAL, W_IDLE, W_BUSY
  } word_kind_e;

  localparam logic [7:0] CODE_NULL    = 8'h00;
  localparam logic [7:0] CODE_CAGAIN  = 8'h01;
  localparam logic [7:0] CODE_ILLEGAL = 8'h02;

  localparam logic [7:0] SZ_IDLE_V0 = 8'h18;
  localparam logic [7:0] SZ_BUSY_V0 = 8'hB4;
  localparam logic [7:0] SZ_IDLE_V1 = 8'h38;
  localparam logic [7:0] SZ_BUSY_V1 = 8'hD4;

  localparam logic [7:0]  TAG_IDLE = 8'h1D;
  localparam logic [7:0]  TAG_BUSY = 8'hB5;
  localparam logic [15:0] DATA_MIX = 16'hC0DE;

endpackage

// File: rtl/cp_save_fsm.sv
module cp_save_fsm
  import cp_save_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int IDLE_LW = 6,
  parameter int BUSY_LW = 45
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_rd_i,
  input  logic             freeze_i,
  input  logic             opnd_rd_i,
  input  logic             abort_i,
  input  logic             exec_start_i,
  input  logic             exec_done_i,
  input  logic             rstr_start_i,
  input  logic             rstr_end_i,
  input  logic             rstr_null_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  output word_kind_e       kind_o,
  output logic             beat_o,
  output logic             beat_err_o,
  output logic [CNT_W-1:0] beat_idx_o,
  output logic             busy_frm_o
);

  phase_e           ph_q, ph_d, ret_q, ret_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bsy_q, bsy_d;

  assign beat_o     = opnd_rd_i && (ph_q == PH_XFER) && !abort_i && !save_rd_i;
  assign beat_err_o = opnd_rd_i && !beat_o;
  assign beat_idx_o = cnt_q - CNT_W'(1);
  assign busy_frm_o = bsy_q;

  always_comb begin
    unique case (ph_q)
      PH_NULL: kind_o = W_NULL;
      PH_IDLE: kind_o = W_IDLE;
      PH_BUSY: kind_o = freeze_i ? W_CAGAIN : W_BUSY;
      default: kind_o = W_ILLEGAL;
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    bsy_d = bsy_q;
    ret_d = ret_q;
    if (abort_i) begin
      ph_d  = PH_NULL;
      cnt_d = '0;
    end else if (save_rd_i) begin
      if (ph_q == PH_IDLE) begin
        ph_d  = PH_XFER;
        cnt_d = CNT_W'(IDLE_LW);
        bsy_d = 1'b0;
      end else if (ph_q == PH_BUSY && !freeze_i) begin
        ph_d  = PH_XFER;
        cnt_d = CNT_W'(BUSY_LW);
        bsy_d = 1'b1;
      end
    end else if (beat_o) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_NULL, PH_IDLE: begin
          if (exec_start_i)      ph_d = PH_BUSY;
          else if (rstr_start_i) ph_d = PH_RSTR;
        end
        PH_BUSY: if (exec_done_i) ph_d = PH_IDLE;
        PH_XFER, PH_RSTR: begin
          if (suspend_i) begin
            ret_d = ph_q;
            ph_d  = PH_SUSP;
          end else if (ph_q == PH_RSTR && rstr_end_i) begin
            ph_d = rstr_null_i ? PH_NULL : PH_IDLE;
          end
        end
        PH_SUSP: if (resume_i) ph_d = ret_q;
        default: ph_d = PH_NULL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_NULL;
      ret_q <= PH_XFER;
      cnt_q <= '0;
      bsy_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      ret_q <= ret_d;
      cnt_q <= cnt_d;
      bsy_q <= bsy_d;
    end
  end

endmodule

// File: rtl/cp_save_word_enc.sv
module cp_save_word_enc
  import cp_save_pkg::*;
#(
  parameter int         VARIANT = 0,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  word_kind_e  kind_i,
  output logic [15:0] word_o
);

  logic [7:0] sz_idle, sz_busy;

  generate
    if (VARIANT == 0) begin : g_v0
      assign sz_idle = SZ_IDLE_V0;
      assign sz_busy = SZ_BUSY_V0;
    end else begin : g_v1
      assign sz_idle = SZ_IDLE_V1;
      assign sz_busy = SZ_BUSY_V1;
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      W_NULL:    word_o = {CODE_NULL, 8'h00};
      W_CAGAIN:  word_o = {CODE_CAGAIN, 8'h00};
      W_IDLE:    word_o = {VERSION, sz_idle};
      W_BUSY:    word_o = {VERSION, sz_busy};
      default:   word_o = {CODE_ILLEGAL, 8'h00};
    endcase
  end

endmodule

// File: rtl/cp_save_frame_stub.sv
module cp_save_frame_stub
  import cp_save_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             busy_frm_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic [31:0]      data_o
);

  logic [7:0] idx8;

  assign idx8   = 8'(idx_i);
  assign data_o = {busy_frm_i ? TAG_BUSY : TAG_IDLE, idx8, DATA_MIX ^ {idx8, idx8}};

endmodule

// File: rtl/cp_save_resp.sv
module cp_save_resp
  import cp_save_pkg::*;
#(
  parameter int         VARIANT = 0,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        save_rd_i,
  input  logic        freeze_i,
  output logic [15:0] fmt_o,
  output logic        fmt_vld_o,
  input  logic        opnd_rd_i,
  output logic [31:0] opnd_o,
  output logic        opnd_vld_o,
  output logic        proto_err_o,
  input  logic        ctrl_abort_i,
  input  logic        exec_start_i,
  input  logic        exec_done_i,
  input  logic        rstr_start_i,
  input  logic        rstr_end_i,
  input  logic        rstr_null_i,
  input  logic        suspend_i,
  input  logic        resume_i
);

  localparam logic [7:0] IDLE_SZ = (VARIANT == 0) ? SZ_IDLE_V0 : SZ_IDLE_V1;
  localparam logic [7:0] BUSY_SZ = (VARIANT == 0) ? SZ_BUSY_V0 : SZ_BUSY_V1;
  localparam int IDLE_LW = int'(IDLE_SZ) / 4;
  localparam int BUSY_LW = int'(BUSY_SZ) / 4;
  localparam int CNT_W   = $clog2(BUSY_LW + 1);

  word_kind_e       kind;
  logic             beat, beat_err, busy_frm;
  logic [CNT_W-1:0] beat_idx;
  logic [15:0]      word;
  logic [31:0]      frm_data;

  cp_save_fsm #(
    .CNT_W(CNT_W), .IDLE_LW(IDLE_LW), .BUSY_LW(BUSY_LW)
  ) fsm_i (
    .clk_i, .rst_ni, .save_rd_i, .freeze_i, .opnd_rd_i,
    .abort_i(ctrl_abort_i), .exec_start_i, .exec_done_i,
    .rstr_start_i, .rstr_end_i, .rstr_null_i, .suspend_i, .resume_i,
    .kind_o(kind), .beat_o(beat), .beat_err_o(beat_err),
    .beat_idx_o(beat_idx), .busy_frm_o(busy_frm)
  );

  cp_save_word_enc #(.VARIANT(VARIANT), .VERSION(VERSION)) enc_i (
    .kind_i(kind), .word_o(word)
  );

  cp_save_frame_stub #(.CNT_W(CNT_W)) stub_i (
    .busy_frm_i(busy_frm), .idx_i(beat_idx), .data_o(frm_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_o       <= '0;
      fmt_vld_o   <= 1'b0;
      opnd_o      <= '0;
      opnd_vld_o  <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      fmt_vld_o   <= save_rd_i;
      opnd_vld_o  <= beat;
      proto_err_o <= beat_err;
      if (save_rd_i) fmt_o <= word;
      opnd_o      <= beat ? frm_data : '0;
    end
  end

endmodule

// File: rtl/cp_save_resp_chk.sv
module cp_save_resp_chk
  import cp_save_pkg::*;
#(
  parameter int         VARIANT = 0,
  parameter logic [7:0] VERSION = 8'h20
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        save_rd_i,
  input logic        opnd_rd_i,
  input logic        ctrl_abort_i,
  input logic [15:0] fmt_o,
  input logic        fmt_vld_o,
  input logic [31:0] opnd_o,
  input logic        opnd_vld_o,
  input logic        proto_err_o
);

  localparam logic [7:0] IDLE_SZ = (VARIANT == 0) ? SZ_IDLE_V0 : SZ_IDLE_V1;
  localparam logic [7:0] BUSY_SZ = (VARIANT == 0) ? SZ_BUSY_V0 : SZ_BUSY_V1;

  // R1
  fmt_resp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_rd_i |=> fmt_vld_o);

  // R1
  fmt_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_vld_o |-> $past(save_rd_i));

  // R3
  fmt_frame_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_vld_o && fmt_o[15:8] == VERSION) |-> (fmt_o[7:0] == IDLE_SZ || fmt_o[7:0] == BUSY_SZ));

  // R5
  fmt_short_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_vld_o && fmt_o[15:8] != VERSION) |-> (fmt_o[15:8] <= CODE_ILLEGAL && fmt_o[7:0] == 8'h00));

  // R8
  err_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> (opnd_o == 32'h0 && !opnd_vld_o));

  // R8
  opnd_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_rd_i |=> (opnd_vld_o || proto_err_o));

  // R8
  opnd_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_vld_o || proto_err_o) |-> $past(opnd_rd_i));

  // R9
  abort_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_abort_i |=> !opnd_vld_o);

endmodule

bind cp_save_resp cp_save_resp_chk #(.VARIANT(VARIANT), .VERSION(VERSION)) chk_i (.*);

// File: tb/cp_save_resp_tb_top.sv
module cp_save_resp_tb_top;

  localparam logic [7:0] VER     = 8'h20;
  localparam logic [7:0] IDLE_SZ = 8'h18;
  localparam logic [7:0] BUSY_SZ = 8'hB4;
  localparam int IDLE_N = 6;
  localparam int BUSY_N = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_rd = 0, freeze = 0, opnd_rd = 0, abort = 0;
  logic ex_start = 0, ex_done = 0, r_start = 0, r_end = 0, r_null = 0, susp = 0, resm = 0;
  logic [15:0] fmt;
  logic [31:0] opnd;
  logic fmt_vld, opnd_vld, perr;

  int checks = 0, errors = 0;
  int m_ph = 0, m_ret = 3, m_cnt = 0, m_busy = 0;  // 0 null 1 idle 2 busy 3 xfer 4 rstr 5 susp
  bit done = 0;

  always #2 clk = ~clk;

  cp_save_resp #(.VARIANT(0), .VERSION(VER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .save_rd_i(save_rd), .freeze_i(freeze),
    .fmt_o(fmt), .fmt_vld_o(fmt_vld), .opnd_rd_i(opnd_rd), .opnd_o(opnd),
    .opnd_vld_o(opnd_vld), .proto_err_o(perr), .ctrl_abort_i(abort),
    .exec_start_i(ex_start), .exec_done_i(ex_done), .rstr_start_i(r_start),
    .rstr_end_i(r_end), .rstr_null_i(r_null), .suspend_i(susp), .resume_i(resm)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_beat(int busy, int idx);
    logic [7:0] i8 = 8'(idx);
    return {busy != 0 ? 8'hB5 : 8'h1D, i8, 16'hC0DE ^ {i8, i8}};
  endfunction

  // kinds: 0 save, 1 operand, 2 exec start, 3 exec done, 4 restore start,
  // 5 restore end, 6 suspend, 7 resume, 8 abort, 9 idle
  task automatic step(int kind, bit flag, string tag = "");
    string req;
    logic [15:0] ew;
    @(negedge clk);
    case (kind)
      0: begin save_rd = 1; freeze = flag; end
      1: opnd_rd = 1;
      2: ex_start = 1;
      3: ex_done = 1;
      4: r_start = 1;
      5: begin r_end = 1; r_null = flag; end
      6: susp = 1;
      7: resm = 1;
      8: abort = 1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    {save_rd, freeze, opnd_rd, abort, ex_start, ex_done, r_start, r_end, r_null, susp, resm} = '0;
    if (kind == 0) begin
      case (m_ph)
        0: begin ew = 16'h0000; req = "R2"; end
        1: begin ew = {VER, IDLE_SZ}; req = "R3"; m_ph = 3; m_cnt = IDLE_N; m_busy = 0; end
        2: if (flag) begin ew = 16'h0100; req = "R4"; end
           else begin ew = {VER, BUSY_SZ}; req = "R3"; m_ph = 3; m_cnt = BUSY_N; m_busy = 1; end
        default: begin ew = 16'h0200; req = "R5"; end
      endcase
      if (tag != "") req = tag;
      chk(req, "fmt_vld", 32'(fmt_vld), 32'h1);
      chk(req, "fmt", 32'(fmt), 32'(ew));
    end else if (kind == 1) begin
      if (m_ph == 3) begin
        req = (tag != "") ? tag : "R6";
        chk(req, "opnd", opnd, exp_beat(m_busy, m_cnt - 1));
        chk(req, "opnd_vld", 32'(opnd_vld), 32'h1);
        chk(req, "perr", 32'(perr), 32'h0);
        m_cnt--;
        if (m_cnt == 0) m_ph = 1;
      end else begin
        req = (tag != "") ? tag : "R8";
        chk(req, "opnd", opnd, 32'h0);
        chk(req, "opnd_vld", 32'(opnd_vld), 32'h0);
        chk(req, "perr", 32'(perr), 32'h1);
      end
    end else begin
      req = (tag != "") ? tag : (kind == 8) ? "R9" : (kind == 6 || kind == 7) ? "R10" : "R11";
      chk(req, "quiet", {29'h0, fmt_vld, opnd_vld, perr}, 32'h0);
      case (kind)
        2: if (m_ph <= 1) m_ph = 2;
        3: if (m_ph == 2) m_ph = 1;
        4: if (m_ph <= 1) m_ph = 4;
        5: if (m_ph == 4) m_ph = flag ? 0 : 1;
        6: if (m_ph == 3 || m_ph == 4) begin m_ret = m_ph; m_ph = 5; end
        7: if (m_ph == 5) m_ph = m_ret;
        8: begin m_ph = 0; m_cnt = 0; end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0721));
    #9 rst_n = 1;
    #1;
    chk("R1", "reset outputs", {fmt, 13'h0, fmt_vld, opnd_vld, perr}, 32'h0);
    chk("R1", "reset opnd", opnd, 32'h0);
    step(0, 0);                 // R2 null
    step(0, 0, "R2");
    step(1, 0, "R8");           // no save active
    step(2, 0, "R11");
    step(0, 1, "R4");           // come-again
    step(0, 0, "R3");           // busy word
    step(1, 0); step(1, 0);
    step(0, 0, "R5");           // nested save -> illegal
    step(1, 0, "R5");           // transfer undisturbed
    step(6, 0, "R10");
    step(1, 0, "R10");          // suspended read errors
    step(0, 0, "R5");
    step(7, 0, "R10");
    step(1, 0, "R10");          // continues at next longword
    while (m_ph == 3) step(1, 0);
    step(1, 0, "R8");           // past frame end
    step(0, 0, "R7");           // idle word after last longword
    step(1, 0); step(1, 0); step(1, 0);
    step(6, 0);
    step(0, 0, "R5");
    step(8, 0, "R9");
    step(7, 0, "R9");
    step(1, 0, "R9");
    step(0, 0, "R9");
    step(4, 0, "R11");
    step(0, 0, "R5");
    step(6, 0); step(7, 0);
    step(5, 0, "R11");
    step(0, 0, "R11");          // idle word
    while (m_ph == 3) step(1, 0);
    step(4, 0); step(5, 1, "R2");
    step(0, 0, "R2");
    step(2, 0); step(3, 0, "R11");
    step(0, 0, "R11");
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      case (r)
        0, 1:        step(0, 1'($urandom_range(0, 1)));
        2, 3, 4, 5, 6, 7: step(1, 0);
        8:           step(2, 0);
        9:           step(3, 0);
        10:          step(4, 0);
        11:          step(5, 1'($urandom_range(0, 1)));
        12:          step(6, 0);
        13:          step(7, 0);
        14:          step($urandom_range(0, 7) == 0 ? 8 : 9, 0);
        default:     step(9, 0);
      endcase
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule